// File: doc/BRIEF.md
# Reset and low-power mode controller

This block sits beside the core of a small microcontroller and decides when the core and its peripherals get clock enables. It has three jobs. It turns a raw, active-high reset pin into a clean internal reset, but only after the pin has been seen high for a minimum number of oscillator periods. It holds a four-bit power-control register that software writes. It runs the resulting run / idle / power-down state machine.

A toggle flop divides the oscillator clock by two. The CPU clock enable and the peripheral clock enable are both taken from that divided phase, so the duty cycle of the input clock has no effect on them. While the block is in a low-power state, it also produces the forced levels for the address-latch strobe and the code-read strobe. It tells the pad logic whether the low multiplexed port must release its drivers and whether the high port must keep showing the address. These outputs depend on the current mode and on whether code is being fetched from external memory.

The power-down state stops the oscillator-run enable, and only a qualified reset pulse can end it. The idle state gates only the CPU and is left as soon as an enabled interrupt is pending.

Top module: `lpm_ctrl`

## Requirements
- R1: `sys_rst` is 1 only after `rst_pin` has been sampled high on 24 consecutive rising edges of `osc_clk`, and it stays 1 while the pin stays high. A pulse that is sampled high on 23 edges never raises `sys_rst`.
- R2: While `sys_rst` is 1, the next clock edge clears all four power-control bits and returns the block to run mode. After that edge `osc_run` is 1 and `cpu_ce` pulses again.
- R3: The power-control register `pcr_q` has the idle request at bit 0, the power-down request at bit 1, and two free software flags at bits 2 and 3. `arst_n` low clears it to 0. In run mode, a write with `pcr_we` = 1 stores `pcr_wdata` on the clock edge, and `pcr_q` reads it back.
- R4: The low-power state begins on the clock edge after the edge that stored the request bit. During the cycle right after the write, the overrides are still inactive.
- R5: If bits 0 and 1 are both 1, the block enters power-down, not idle.
- R6: In idle, `cpu_ce` is 0, while `per_ce` keeps pulsing and `osc_run` stays 1. In either low-power state, register writes are ignored.
- R7: In idle, `irq_pend` = 1 on a clock edge returns the block to run mode on that edge. The same edge clears bit 0 and leaves bits 1 to 3 unchanged.
- R8: In power-down, `osc_run`, `cpu_ce` and `per_ce` are 0. `irq_pend` has no effect, and only a qualified reset ends the state.
- R9: `ale_frc` is 1 exactly in the low-power states. The forced strobe levels `ale_val` and `psen_n_val` are 1 in idle and 0 in power-down.
- R10: In a low-power state with `ext_code` = 1, `lo_oe_off` is 1; with `ext_code` = 0 it is 0. `hi_addr_keep` is 1 only in idle with `ext_code` = 1. Both are 0 in run mode.
- R11: The clock enables come from a divide-by-two phase. When active, `cpu_ce` and `per_ce` are high on every other oscillator edge, which gives exactly 2 of any 4 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| rst_pin | input | 1 | Raw reset pin, active high, qualified by duration |
| pcr_we | input | 1 | Write strobe for the power-control register |
| pcr_wdata | input | 4 | Write data: bit0 idle, bit1 power-down, bit2/3 flags |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_code | input | 1 | Code is fetched from external memory |
| sys_rst | output | 1 | Qualified internal reset |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| pcr_q | output | 4 | Power-control register contents |
| ale_frc | output | 1 | Strobe override active |
| ale_val | output | 1 | Forced address-latch strobe level |
| psen_n_val | output | 1 | Forced code-read strobe level (active low) |
| lo_oe_off | output | 1 | Force low multiplexed port drivers off |
| hi_addr_keep | output | 1 | High port keeps showing the address |

## Verification
The hardest case to reach is the exit from power-down. The only way out is a reset pulse on the pin, and that pulse must be long enough by exactly one oscillator period. To get there, the stimulus first enters power-down with both request bits written together. It then checks that an interrupt does nothing. Next it applies a pulse sampled high on 23 edges and checks every cycle that nothing changes. Finally it applies a 24-edge pulse and checks that `sys_rst` rises on the 24th edge, with the block still powered down, and that the following edge restores run mode with a cleared register.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_IDLE  = 2'd1,
    MD_PDOWN = 2'd2
  } lp_mode_e;

  localparam int PCR_W   = 4;
  localparam int IDL_BIT = 0;
  localparam int PD_BIT  = 1;
  localparam int GF0_BIT = 2;
  localparam int GF1_BIT = 3;
endpackage

// File: rtl/lpm_rst_qual.sv
// Counts consecutive oscillator edges with the reset pin high; saturates.
module lpm_rst_qual #(
  parameter int RST_OSC_CYC = 24
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rst_pin,
  output logic rst_act
);
  localparam int CNT_W = $clog2(RST_OSC_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_OSC_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!rst_pin)              cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign rst_act = (cnt_q == CNT_MAX);
endmodule

// File: rtl/lpm_clkdiv.sv
// Divide-by-two phase; frozen while the oscillator is stopped.
module lpm_clkdiv (
  input  logic clk,
  input  logic arst_n,
  input  logic run_en,
  output logic ph
);
  logic ph_q, ph_d;

  always_comb ph_d = run_en ? ~ph_q : ph_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ph_q <= 1'b0;
    else         ph_q <= ph_d;
  end

  assign ph = ph_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rst_act,
  input  logic             pcr_we,
  input  logic [PCR_W-1:0] pcr_wdata,
  input  logic             irq_pend,
  output lp_mode_e         mode,
  output logic [PCR_W-1:0] pcr
);
  lp_mode_e         mode_q, mode_d;
  logic [PCR_W-1:0] pcr_q, pcr_d;

  always_comb begin
    mode_d = mode_q;
    pcr_d  = pcr_q;
    if (rst_act) begin
      mode_d = MD_RUN;
      pcr_d  = '0;
    end else begin
      unique case (mode_q)
        MD_RUN: begin
          // request bits already stored: enter on this edge (PD wins)
          if (pcr_q[PD_BIT])       mode_d = MD_PDOWN;
          else if (pcr_q[IDL_BIT]) mode_d = MD_IDLE;
          if (pcr_we) pcr_d = pcr_wdata;
        end
        MD_IDLE: begin
          if (irq_pend) begin
            mode_d         = MD_RUN;
            pcr_d[IDL_BIT] = 1'b0;
          end
        end
        MD_PDOWN: mode_d = MD_PDOWN;
        default:  mode_d = MD_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q <= MD_RUN;
      pcr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      pcr_q  <= pcr_d;
    end
  end

  assign mode = mode_q;
  assign pcr  = pcr_q;
endmodule

// File: rtl/lpm_pin_ovr.sv
module lpm_pin_ovr
  import lpm_pkg::*;
(
  input  lp_mode_e mode,
  input  logic     ext_code,
  output logic     ale_frc,
  output logic     ale_val,
  output logic     psen_n_val,
  output logic     lo_oe_off,
  output logic     hi_addr_keep
);
  logic low_pwr, in_idle;

  always_comb begin
    low_pwr      = (mode != MD_RUN);
    in_idle      = (mode == MD_IDLE);
    ale_frc      = low_pwr;
    ale_val      = in_idle;
    psen_n_val   = in_idle;
    lo_oe_off    = low_pwr & ext_code;
    hi_addr_keep = in_idle & ext_code;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int RST_OSC_CYC = 24
) (
  input  logic             osc_clk,
  input  logic             arst_n,
  input  logic             rst_pin,
  input  logic             pcr_we,
  input  logic [PCR_W-1:0] pcr_wdata,
  input  logic             irq_pend,
  input  logic             ext_code,
  output logic             sys_rst,
  output logic             cpu_ce,
  output logic             per_ce,
  output logic             osc_run,
  output logic [PCR_W-1:0] pcr_q,
  output logic             ale_frc,
  output logic             ale_val,
  output logic             psen_n_val,
  output logic             lo_oe_off,
  output logic             hi_addr_keep
);
  logic     rst_act, ph;
  lp_mode_e mode;

  lpm_rst_qual #(.RST_OSC_CYC(RST_OSC_CYC)) u_rst (
    .clk(osc_clk), .arst_n(arst_n), .rst_pin(rst_pin), .rst_act(rst_act)
  );

  lpm_mode_fsm u_fsm (
    .clk(osc_clk), .arst_n(arst_n), .rst_act(rst_act), .pcr_we(pcr_we),
    .pcr_wdata(pcr_wdata), .irq_pend(irq_pend), .mode(mode), .pcr(pcr_q)
  );

  lpm_clkdiv u_div (
    .clk(osc_clk), .arst_n(arst_n), .run_en(osc_run), .ph(ph)
  );

  lpm_pin_ovr u_pin (
    .mode(mode), .ext_code(ext_code), .ale_frc(ale_frc), .ale_val(ale_val),
    .psen_n_val(psen_n_val), .lo_oe_off(lo_oe_off), .hi_addr_keep(hi_addr_keep)
  );

  always_comb begin
    sys_rst = rst_act;
    osc_run = (mode != MD_PDOWN);
    per_ce  = ph & osc_run;
    cpu_ce  = ph & (mode == MD_RUN);
  end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       osc_clk,
  input logic       arst_n,
  input logic       rst_pin,
  input logic       irq_pend,
  input logic       sys_rst,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic       osc_run,
  input logic [3:0] pcr_q,
  input logic       ale_frc,
  input logic       ale_val,
  input logic       psen_n_val
);
  // R1
  rst_pin_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    $rose(sys_rst) |-> $past(rst_pin));
  // R8
  pd_hold_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (!osc_run && !sys_rst) |=> !osc_run);
  // R9
  strobe_lvl_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    ale_frc |-> (ale_val == osc_run) && (psen_n_val == osc_run));
  // R6
  cpu_gate_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    ale_frc |-> !cpu_ce);
  // R6
  flag_keep_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (ale_frc && !sys_rst) |=> $stable(pcr_q[3:2]));
  // R7
  idle_wake_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    (ale_frc && osc_run && irq_pend) |=> !ale_frc);
  // R11
  per_alt_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    per_ce |=> !per_ce);
  // R11
  cpu_alt_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    cpu_ce |=> !cpu_ce);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .osc_clk(osc_clk), .arst_n(arst_n), .rst_pin(rst_pin), .irq_pend(irq_pend),
  .sys_rst(sys_rst), .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_run(osc_run),
  .pcr_q(pcr_q), .ale_frc(ale_frc), .ale_val(ale_val), .psen_n_val(psen_n_val)
);

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;
  logic       osc_clk = 1'b0;
  logic       arst_n, rst_pin, pcr_we, irq_pend, ext_code;
  logic [3:0] pcr_wdata;
  logic       sys_rst, cpu_ce, per_ce, osc_run;
  logic [3:0] pcr_q;
  logic       ale_frc, ale_val, psen_n_val, lo_oe_off, hi_addr_keep;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [10:0] exp;
  } item_t;
  item_t sbq[$];

  always #2.5 osc_clk = ~osc_clk;

  lpm_ctrl dut (
    .osc_clk(osc_clk), .arst_n(arst_n), .rst_pin(rst_pin), .pcr_we(pcr_we),
    .pcr_wdata(pcr_wdata), .irq_pend(irq_pend), .ext_code(ext_code),
    .sys_rst(sys_rst), .cpu_ce(cpu_ce), .per_ce(per_ce), .osc_run(osc_run),
    .pcr_q(pcr_q), .ale_frc(ale_frc), .ale_val(ale_val),
    .psen_n_val(psen_n_val), .lo_oe_off(lo_oe_off), .hi_addr_keep(hi_addr_keep)
  );

  function automatic logic [10:0] obs();
    return {sys_rst, osc_run, pcr_q, ale_frc, ale_val, psen_n_val,
            lo_oe_off, hi_addr_keep};
  endfunction

  function automatic logic [10:0] mk(logic sr, logic osc, logic [3:0] pcr,
                                      logic af, logic av, logic pv,
                                      logic lo, logic hi);
    return {sr, osc, pcr, af, av, pv, lo, hi};
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor: pops expected items just after the sampling edge
  always @(negedge osc_clk) begin
    #1;
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      chk(it.tag, int'(obs()), int'(it.exp));
    end
  end

  task automatic tick();
    @(posedge osc_clk);
    @(negedge osc_clk);
  endtask

  task automatic push(string tag, logic [10:0] e);
    item_t it;
    it.tag = tag;
    it.exp = e;
    sbq.push_back(it);
    #2;
  endtask

  task automatic write_pcr(logic [3:0] v);
    pcr_we    = 1'b1;
    pcr_wdata = v;
    tick();
    pcr_we    = 1'b0;
  endtask

  task automatic count_ce(int n, output int nc, output int np);
    nc = 0;
    np = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      #1;
      nc += int'(cpu_ce);
      np += int'(per_ce);
    end
  endtask

  initial begin
    int nc, np;
    arst_n = 1'b0; rst_pin = 1'b0; pcr_we = 1'b0; pcr_wdata = '0;
    irq_pend = 1'b0; ext_code = 1'b0;
    repeat (3) @(posedge osc_clk);
    @(negedge osc_clk);
    arst_n = 1'b1;
    tick();
    push("R3 reset state", mk(0, 1, 4'b0000, 0, 0, 0, 0, 0));

    // R11 divided enables in run mode
    count_ce(4, nc, np);
    chk("R11 cpu_ce run count", nc, 2);
    chk("R11 per_ce run count", np, 2);

    // R3 flags only: stored, no mode change
    write_pcr(4'b1100);
    push("R3 flag write", mk(0, 1, 4'b1100, 0, 0, 0, 0, 0));
    tick();
    push("R3 flags no mode", mk(0, 1, 4'b1100, 0, 0, 0, 0, 0));

    // R4 idle entered one edge after the write
    write_pcr(4'b1101);
    push("R4 run right after write", mk(0, 1, 4'b1101, 0, 0, 0, 0, 0));
    tick();
    push("R9 idle strobes", mk(0, 1, 4'b1101, 1, 1, 1, 0, 0));
    ext_code = 1'b1;
    #0.5;
    push("R10 idle ext code", mk(0, 1, 4'b1101, 1, 1, 1, 1, 1));
    count_ce(4, nc, np);
    chk("R6 idle cpu_ce count", nc, 0);
    chk("R6 idle per_ce count", np, 2);

    // R6 writes ignored in idle
    write_pcr(4'b0011);
    push("R6 idle write ignored", mk(0, 1, 4'b1101, 1, 1, 1, 1, 1));

    // R7 wake on interrupt
    irq_pend = 1'b1;
    tick();
    irq_pend = 1'b0;
    push("R7 idle wake", mk(0, 1, 4'b1100, 0, 0, 0, 0, 0));
    tick();
    push("R7 stays run", mk(0, 1, 4'b1100, 0, 0, 0, 0, 0));

    // R5 both bits: power-down wins
    write_pcr(4'b0011);
    push("R4 pd not yet", mk(0, 1, 4'b0011, 0, 0, 0, 0, 0));
    tick();
    push("R5 pd priority", mk(0, 0, 4'b0011, 1, 0, 0, 1, 0));
    ext_code = 1'b0;
    #0.5;
    push("R10 pd int code", mk(0, 0, 4'b0011, 1, 0, 0, 0, 0));
    count_ce(4, nc, np);
    chk("R8 pd cpu_ce count", nc, 0);
    chk("R8 pd per_ce count", np, 0);

    // R8 interrupt ignored in power-down
    irq_pend = 1'b1;
    tick();
    tick();
    irq_pend = 1'b0;
    push("R8 irq ignored", mk(0, 0, 4'b0011, 1, 0, 0, 0, 0));

    // R1 23-edge pulse ignored
    rst_pin = 1'b1;
    for (int i = 0; i < 23; i++) begin
      tick();
      push("R1 short pulse", mk(0, 0, 4'b0011, 1, 0, 0, 0, 0));
    end
    rst_pin = 1'b0;
    tick();
    push("R1 short pulse after", mk(0, 0, 4'b0011, 1, 0, 0, 0, 0));

    // R1 24-edge pulse qualifies
    rst_pin = 1'b1;
    for (int i = 0; i < 23; i++) begin
      tick();
      push("R1 long pulse pre", mk(0, 0, 4'b0011, 1, 0, 0, 0, 0));
    end
    tick();
    push("R1 reset asserted", mk(1, 0, 4'b0011, 1, 0, 0, 0, 0));
    rst_pin = 1'b0;
    tick();
    push("R2 reset clears", mk(0, 1, 4'b0000, 0, 0, 0, 0, 0));
    count_ce(4, nc, np);
    chk("R2 cpu_ce resumes", nc, 2);

    // R1 held reset stays asserted; R2 clears flags too
    write_pcr(4'b1000);
    rst_pin = 1'b1;
    repeat (24) tick();
    push("R1 held asserted", mk(1, 1, 4'b1000, 0, 0, 0, 0, 0));
    tick();
    push("R1 still held", mk(1, 1, 4'b0000, 0, 0, 0, 0, 0));
    rst_pin = 1'b0;
    tick();
    push("R2 released", mk(0, 1, 4'b0000, 0, 0, 0, 0, 0));

    tick();
    tick();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule